// File: doc/BRIEF.md
# Mask-Driven Compress and Expand Unit

This block rearranges the elements of one vector register under a per-element bit mask. In compress mode the elements whose mask bit is set are packed, in ascending index order, into the lowest result positions. In expand mode the lowest source elements are handed out, one each and in order, to the positions whose mask bit is set. Positions that receive no element keep the value of an old destination operand. No element is ever reordered or written twice, so the block is a restricted, order-keeping counterpart to a general index-driven permute.

A caller presents the source vector, the mask, the old destination and a mode bit, then pulses `start` for one cycle. On the next clock edge the whole result is computed in one pass of combinational logic and registered. `done` is high for that one following cycle, and the result and the count of set mask bits stay stable until the next `start`. Element `i` of every vector port occupies bits `[i*ELEM_W +: ELEM_W]`. `NUM_ELEM` must be at least 2.

Top module: `mask_pack_unit`

## Requirements
- R1: A cycle with `start` high is followed by exactly one cycle of `done` high, with the new result and count visible in that cycle; `done` is never high except in the cycle after a `start` cycle.
- R2: `count` equals the number of set bits in the mask captured with `start`, in both modes.
- R3: With `mode` = 0 (compress), result position j, for j below `count`, holds the source element with the j-th lowest index among those whose mask bit is 1.
- R4: With `mode` = 0, result positions at or above `count` hold the old destination element of the same position.
- R5: With `mode` = 1 (expand), a position i whose mask bit is 1 holds source element k, where k is the number of set mask bits below i.
- R6: With `mode` = 1, a position whose mask bit is 0 holds the old destination element of the same position.
- R7: An all-zero mask yields a result equal to the old destination and a count of 0, in either mode.
- R8: An all-ones mask yields a result equal to the source vector and a count of `NUM_ELEM`, in either mode.
- R9: While `start` is low, changes on `mode`, `mask`, `src` and `old_dst` have no effect on `result`, `count` or `done`.
- R10: After a reset cycle (`rst_n` low at a clock edge), `done` is 0, `result` is all zeros and `count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to run an operation on the current inputs |
| mode | input | 1 | 0 = compress, 1 = expand |
| mask | input | NUM_ELEM | One select bit per element, bit i for element i |
| src | input | NUM_ELEM*ELEM_W | Source vector |
| old_dst | input | NUM_ELEM*ELEM_W | Old destination value kept in unwritten positions |
| done | output | 1 | High for one cycle after `start` |
| result | output | NUM_ELEM*ELEM_W | Registered result vector |
| count | output | $clog2(NUM_ELEM+1) | Number of set mask bits of the last operation |

## Verification
A wrong running prefix count inside the unit shows up at the ports in the very cycle `done` rises: an element lands one slot off, appears twice with another missing, or an old destination value survives where a source element belongs. Because every operation settles in one registered step, any routing or count defect is visible in the first operation whose mask exercises it, so masks with isolated bits, runs of bits, the lowest and highest element, and the empty and full cases are each driven in both modes. A fault in the capture logic shows instead as a result that drifts while `start` is low, which the hold scenario watches over several idle cycles.

// File: rtl/mpk_pkg.sv
// Shared types for the mask-driven compress/expand unit.
// Assumes nothing beyond a 1-bit mode encoding on the top-level port.
package mpk_pkg;

    typedef enum logic {
        MPK_COMPRESS = 1'b0,
        MPK_EXPAND   = 1'b1
    } mpk_mode_e;

endpackage

// File: rtl/mpk_prefix.sv
// Running population count of the mask.
// For each element i, below[i] is the number of set mask bits at indices
// lower than i; total is the number of set bits in the whole mask.
// Assumes CNT_W is wide enough to hold NUM_ELEM.
module mpk_prefix #(
    parameter int NUM_ELEM = 8,
    parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
    input  logic [NUM_ELEM-1:0]       mask,
    output logic [NUM_ELEM*CNT_W-1:0] below,
    output logic [CNT_W-1:0]          total
);

    logic [CNT_W-1:0] run [0:NUM_ELEM];

    assign run[0] = '0;

    // One adder stage per element: carry the running count forward.
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_stage
        assign run[g+1] = run[g] + CNT_W'(mask[g]);
        assign below[g*CNT_W +: CNT_W] = run[g];
    end

    assign total = run[NUM_ELEM];

endmodule

// File: rtl/mpk_route.sv
// Combinational routing network for compress and expand.
// Compress: output slot j takes the unique masked source whose prefix
// count equals j, else the old destination element.
// Expand: a masked position i takes the source element indexed by its
// prefix count, else the old destination element.
// Assumes below/total come from mpk_prefix on the same mask, NUM_ELEM >= 2.
module mpk_route
    import mpk_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int ELEM_W   = 32,
    parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
    input  mpk_mode_e                  mode,
    input  logic [NUM_ELEM-1:0]        mask,
    input  logic [NUM_ELEM*CNT_W-1:0]  below,
    input  logic [NUM_ELEM*ELEM_W-1:0] src,
    input  logic [NUM_ELEM*ELEM_W-1:0] old_dst,
    output logic [NUM_ELEM*ELEM_W-1:0] res
);

    localparam int IDX_W = $clog2(NUM_ELEM);

    logic [ELEM_W-1:0] src_e [NUM_ELEM];
    logic [CNT_W-1:0]  pre_e [NUM_ELEM];

    // Unpack flat vectors into per-element arrays.
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_unpack
        assign src_e[g] = src[g*ELEM_W +: ELEM_W];
        assign pre_e[g] = below[g*CNT_W +: CNT_W];
    end

    for (genvar j = 0; j < NUM_ELEM; j++) begin : g_slot
        logic [ELEM_W-1:0] cmp_pick;
        logic              cmp_hit;
        logic [ELEM_W-1:0] exp_val;
        logic [IDX_W-1:0]  exp_idx;

        // Compress: OR together the single source aimed at slot j.
        always_comb begin
            cmp_pick = '0;
            cmp_hit  = 1'b0;
            for (int i = j; i < NUM_ELEM; i++) begin
                if (mask[i] && (pre_e[i] == CNT_W'(j))) begin
                    cmp_pick = cmp_pick | src_e[i];
                    cmp_hit  = 1'b1;
                end
            end
        end

        // Expand: a set bit at j fetches the source at its prefix count.
        always_comb begin
            exp_idx = pre_e[j][IDX_W-1:0];
            exp_val = mask[j] ? src_e[exp_idx] : old_dst[j*ELEM_W +: ELEM_W];
        end

        // Mode select for slot j.
        always_comb begin
            if (mode == MPK_COMPRESS)
                res[j*ELEM_W +: ELEM_W] = cmp_hit ? cmp_pick : old_dst[j*ELEM_W +: ELEM_W];
            else
                res[j*ELEM_W +: ELEM_W] = exp_val;
        end
    end

endmodule

// File: rtl/mask_pack_unit.sv
// Top level of the mask-driven compress/expand unit.
// On a start cycle the inputs are routed in one combinational pass and
// the result and mask population count are registered; done follows for
// one cycle and the outputs hold until the next start.
// Assumes synchronous active-low reset and NUM_ELEM >= 2.
module mask_pack_unit
    import mpk_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int ELEM_W   = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic                               mode,
    input  logic [NUM_ELEM-1:0]                mask,
    input  logic [NUM_ELEM*ELEM_W-1:0]         src,
    input  logic [NUM_ELEM*ELEM_W-1:0]         old_dst,
    output logic                               done,
    output logic [NUM_ELEM*ELEM_W-1:0]         result,
    output logic [$clog2(NUM_ELEM+1)-1:0]      count
);

    localparam int CNT_W = $clog2(NUM_ELEM + 1);
    localparam int VEC_W = NUM_ELEM * ELEM_W;

    logic [NUM_ELEM*CNT_W-1:0] below;
    logic [CNT_W-1:0]          total;
    logic [VEC_W-1:0]          routed;
    mpk_mode_e                 mode_e;

    assign mode_e = mpk_mode_e'(mode);

    mpk_prefix #(
        .NUM_ELEM (NUM_ELEM),
        .CNT_W    (CNT_W)
    ) u_prefix (
        .mask  (mask),
        .below (below),
        .total (total)
    );

    mpk_route #(
        .NUM_ELEM (NUM_ELEM),
        .ELEM_W   (ELEM_W),
        .CNT_W    (CNT_W)
    ) u_route (
        .mode    (mode_e),
        .mask    (mask),
        .below   (below),
        .src     (src),
        .old_dst (old_dst),
        .res     (routed)
    );

    // Capture the routed vector and count on start; pulse done once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
            count  <= '0;
        end else begin
            done <= start;
            if (start) begin
                result <= routed;
                count  <= total;
            end
        end
    end

    a_r1_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r1_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(count)));

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(NUM_ELEM));

    a_r7_empty_mask_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (mask == '0)) |=> ((count == '0) && (result == $past(old_dst))));

    a_r8_full_mask_copies_src: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (&mask)) |=> ((count == CNT_W'(NUM_ELEM)) && (result == $past(src))));

endmodule

// File: tb/sim_mask_pack_unit.sv
module sim_mask_pack_unit;

    localparam int  N      = 8;
    localparam int  W      = 32;
    localparam int  CW     = $clog2(N + 1);
    localparam int  VW     = N * W;
    localparam time CLK_PD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [N-1:0]  mask = '0;
    logic [VW-1:0] src = '0;
    logic [VW-1:0] old_dst = '0;
    logic          done;
    logic [VW-1:0] result;
    logic [CW-1:0] count;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PD/2) clk = ~clk;

    mask_pack_unit #(.NUM_ELEM(N), .ELEM_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .mask(mask),
        .src(src), .old_dst(old_dst), .done(done), .result(result), .count(count)
    );

    task automatic chk_vec(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference models written from R3..R6.
    function automatic logic [VW-1:0] ref_vec(logic md, logic [N-1:0] m,
                                              logic [VW-1:0] s, logic [VW-1:0] o);
        logic [VW-1:0] r = o;
        int k = 0;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                if (md == 1'b0) r[k*W +: W] = s[i*W +: W];
                else            r[i*W +: W] = s[k*W +: W];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] pattern(int base);
        logic [VW-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(base + i * 32'h0101);
        return v;
    endfunction

    // Run one operation and check it; tag names the requirement.
    task automatic run_op(string tag, logic md, logic [N-1:0] m,
                          logic [VW-1:0] s, logic [VW-1:0] o);
        @(negedge clk);
        mode = md; mask = m; src = s; old_dst = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_int({tag, " R1 done"}, int'(done), 1);
        chk_vec({tag, " result"}, result, ref_vec(md, m, s, o));
        chk_int({tag, " R2 count"}, int'(count), $countones(m));
        @(negedge clk);
        chk_int({tag, " R1 done drops"}, int'(done), 0);
    endtask

    task automatic t_reset();
        chk_int("R10 done", int'(done), 0);
        chk_vec("R10 result", result, '0);
        chk_int("R10 count", int'(count), 0);
    endtask

    task automatic t_compress();
        run_op("R3 R4 compress sparse", 1'b0, 8'b1010_0110, pattern(32'h1000), pattern(32'hA000));
        run_op("R3 R4 compress top bit", 1'b0, 8'b1000_0000, pattern(32'h2000), pattern(32'hB000));
        run_op("R3 compress low run", 1'b0, 8'b0000_0111, pattern(32'h3000), pattern(32'hC000));
    endtask

    task automatic t_expand();
        run_op("R5 R6 expand sparse", 1'b1, 8'b0101_1001, pattern(32'h4000), pattern(32'hD000));
        run_op("R5 R6 expand bottom bit", 1'b1, 8'b0000_0001, pattern(32'h5000), pattern(32'hE000));
        run_op("R5 expand high run", 1'b1, 8'b1111_0000, pattern(32'h6000), pattern(32'hF000));
    endtask

    task automatic t_edges();
        run_op("R7 empty compress", 1'b0, 8'h00, pattern(32'h7000), pattern(32'h7700));
        chk_vec("R7 compress keeps old", result, pattern(32'h7700));
        run_op("R7 empty expand", 1'b1, 8'h00, pattern(32'h7100), pattern(32'h7800));
        chk_vec("R7 expand keeps old", result, pattern(32'h7800));
        run_op("R8 full compress", 1'b0, 8'hFF, pattern(32'h8000), pattern(32'h8800));
        chk_vec("R8 compress copies src", result, pattern(32'h8000));
        run_op("R8 full expand", 1'b1, 8'hFF, pattern(32'h8100), pattern(32'h8900));
        chk_vec("R8 expand copies src", result, pattern(32'h8100));
    endtask

    task automatic t_hold();
        logic [VW-1:0] keep;
        logic [CW-1:0] kc;
        run_op("R9 setup", 1'b0, 8'b0011_0100, pattern(32'h9000), pattern(32'h9900));
        keep = result; kc = count;
        mode = 1'b1; mask = 8'hFF; src = pattern(32'h1234); old_dst = pattern(32'h4321);
        repeat (4) @(negedge clk);
        chk_vec("R9 result held", result, keep);
        chk_int("R9 count held", int'(count), int'(kc));
        chk_int("R9 no done", int'(done), 0);
    endtask

    task automatic t_sweep();
        for (int t = 0; t < 40; t++) begin
            run_op("R3 R4 R5 R6 sweep", t[0], N'($urandom), pattern($urandom), pattern($urandom));
        end
    endtask

    initial begin
        #(CLK_PD * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_compress();
        t_expand();
        t_edges();
        t_hold();
        t_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule